// File: doc/BRIEF.md
# Pseudo-Static RAM Access Sequencer

This block sits between a host and an asynchronous pseudo-static RAM. The RAM has a flat 19-bit address and an 8-bit shared data bus. A host request holds an operation code, an address and write data. The sequencer turns each request into exactly one active-low chip-select pulse. Around that pulse it places the output-enable and write-enable strobes and a drive enable for the shared bus. Every timing figure is given as a parameter in clock cycles: the minimum select width, the write pulse, the precharge, the read/write cycle and the read-modify-write cycle. Because all of them are cycle counts, the same RTL fits any speed grade of the memory once the clock period is known.

After reset the sequencer keeps the memory idle for a programmable settling delay. It then runs a fixed number of dummy select pulses before it raises `ready` for the first time. Read data comes back on a one-cycle `rd_valid` pulse. The host may present a request only while `ready` is high. The RAM control lines and the bus drive enable all come straight from flip-flops, so they never carry a decode glitch.

Top module: `psram_seq`

## Requirements
- R1: `mem_addr` is stable for every cycle that `mem_ce_n` is low and for the first cycle after it returns high.
- R2: The chip-select low pulse lasts exactly `T_CE` cycles for a read, a write or a dummy cycle, and `T_CE+1+T_WP` cycles for a read-modify-write. It never lasts longer than `MAX_CE_LOW` cycles.
- R3: Between pulses `mem_ce_n` stays high for at least `T_PRE` cycles. Two successive falling edges are at least `T_CYC` cycles apart, or `T_RMW` cycles when the earlier access was a read-modify-write.
- R4: A write (`req_op` = 2'b01) holds `mem_we_n` low for the whole select window, with `mem_oe_n` high. `mem_dq_out` is driven and stable all the while `mem_we_n` is low, and `mem_we_n` rises together with `mem_ce_n`. The bus drive stays on for one cycle after that rise, so the addressed location takes the request data.
- R5: A read (`req_op` = 2'b00, and 2'b11 is treated the same) holds `mem_oe_n` low and `mem_we_n` high. It samples `mem_dq_in` on the last low cycle of the select window. It returns the sample on `rd_data` with `rd_valid` high for exactly one cycle, `T_CE` cycles after the request is accepted.
- R6: A read-modify-write (`req_op` = 2'b10) first reads as in R5. It then raises `mem_oe_n`, and one cycle later drives the bus and pulls `mem_we_n` low for `T_WP` cycles, all inside a single select pulse. `rd_data` returns the old contents and the location ends up holding the new data.
- R7: Out of reset all strobes are inactive and `ready` is low. The first select pulse comes no earlier than `PWRUP_CYC` cycles after reset. Exactly `N_DUMMY` dummy pulses, with output enable and write enable both high, come before `ready` first rises.
- R8: `ready` is high only while the sequencer is idle with the memory deselected. A request is taken only on a cycle where `ready` is high, and `ready` drops in the cycle after acceptance. `req_valid` held while `ready` is low starts no access and changes no memory contents.
- R9: `mem_dq_oe` is high only while `mem_oe_n` is high, and it rises only after `mem_oe_n` has been high for at least one cycle. The two ends of the bus therefore never drive at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present, taken when `ready` is high |
| req_op | input | 2 | 00 read, 01 write, 10 read-modify-write, 11 read |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Data to write |
| ready | output | 1 | Sequencer idle and able to take a request |
| rd_valid | output | 1 | One-cycle strobe marking `rd_data` |
| rd_data | output | DW | Data read from memory |
| mem_addr | output | AW | Address to the memory |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_out | output | DW | Data the host drives onto the bus |
| mem_dq_oe | output | 1 | Host bus drive enable |
| mem_dq_in | input | DW | Data seen on the bus |

## Verification
The bound checker watches the strobe rules on every cycle. It checks the address hold, the pulse width limits, the precharge and cycle spacing, the write-data stability and hold, the single-cycle read strobe and the bus-ownership handover, using its own run-length counters. Only the bench scenarios can show that the data is right. These cover write, read and read-modify-write sweeps over 64 addresses, against a pin-level memory model that commits writes on the rising strobe. The scenarios also cover the power-up count of dummy pulses, a request ignored while busy, and the read latency.

// File: rtl/psram_seq.sv
module psram_seq #(
  parameter int AW         = 19,
  parameter int DW         = 8,
  parameter int T_CE       = 7,
  parameter int T_WP       = 3,
  parameter int T_PRE      = 4,
  parameter int T_CYC      = 12,
  parameter int T_RMW      = 16,
  parameter int MAX_CE_LOW = 1000,
  parameter int PWRUP_CYC  = 10000,
  parameter int N_DUMMY    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          ready,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in
);
  localparam int RMW_LOW = T_CE + 1 + T_WP;
  localparam int PRE_RW  = (T_CYC - T_CE > T_PRE) ? T_CYC - T_CE : T_PRE;
  localparam int PRE_RMW = (T_RMW - RMW_LOW > T_PRE) ? T_RMW - RMW_LOW : T_PRE;
  localparam int CNT_MAX = PWRUP_CYC + RMW_LOW + PRE_RW + PRE_RMW;
  localparam int CW      = $clog2(CNT_MAX + 1);
  localparam int DCW     = $clog2(N_DUMMY + 2);

  localparam logic [1:0] OP_RD  = 2'd0;
  localparam logic [1:0] OP_WR  = 2'd1;
  localparam logic [1:0] OP_RMW = 2'd2;
  localparam logic [1:0] OP_DUM = 2'd3;

  if (RMW_LOW > MAX_CE_LOW || T_CE > MAX_CE_LOW) begin : g_bad_width
    $error("select pulse would exceed MAX_CE_LOW");
  end

  typedef enum logic [1:0] {S_PWR, S_IDLE, S_LOW, S_PRE} state_t;

  state_t         st;
  logic [CW-1:0]  cnt;
  logic [DCW-1:0] dum;
  logic [1:0]     op;
  logic [CW-1:0]  pre_last;

  assign ready    = (st == S_IDLE);
  assign pre_last = (op == OP_RMW) ? CW'(PRE_RMW - 1) : CW'(PRE_RW - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_PWR;
      cnt        <= '0;
      dum        <= '0;
      op         <= OP_DUM;
      mem_ce_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_dq_oe  <= 1'b0;
      mem_addr   <= '0;
      mem_dq_out <= '0;
      rd_data    <= '0;
      rd_valid   <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      case (st)
        S_PWR: begin
          if (cnt == CW'(PWRUP_CYC - 1)) begin
            cnt <= '0;
            if (N_DUMMY > 0) begin
              op       <= OP_DUM;
              mem_ce_n <= 1'b0;
              dum      <= DCW'(1);
              st       <= S_LOW;
            end else begin
              st <= S_IDLE;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end

        S_IDLE: begin
          if (req_valid) begin
            mem_addr   <= req_addr;
            mem_dq_out <= req_wdata;
            mem_ce_n   <= 1'b0;
            cnt        <= '0;
            st         <= S_LOW;
            case (req_op)
              2'b01: begin
                op        <= OP_WR;
                mem_we_n  <= 1'b0;
                mem_dq_oe <= 1'b1;
              end
              2'b10: begin
                op       <= OP_RMW;
                mem_oe_n <= 1'b0;
              end
              default: begin
                op       <= OP_RD;
                mem_oe_n <= 1'b0;
              end
            endcase
          end
        end

        S_LOW: begin
          cnt <= cnt + 1'b1;
          if (op == OP_WR) begin
            if (cnt == CW'(T_CE - 1)) begin
              mem_ce_n <= 1'b1;
              mem_we_n <= 1'b1;
              cnt      <= '0;
              st       <= S_PRE;
            end
          end else begin
            if (cnt == CW'(T_CE - 1)) begin
              mem_oe_n <= 1'b1;
              if (op != OP_DUM) begin
                rd_data  <= mem_dq_in;
                rd_valid <= 1'b1;
              end
              if (op != OP_RMW) begin
                mem_ce_n <= 1'b1;
                cnt      <= '0;
                st       <= S_PRE;
              end
            end
            if (op == OP_RMW && cnt == CW'(T_CE)) begin
              mem_dq_oe <= 1'b1;
              mem_we_n  <= 1'b0;
            end
            if (op == OP_RMW && cnt == CW'(RMW_LOW - 1)) begin
              mem_ce_n <= 1'b1;
              mem_we_n <= 1'b1;
              cnt      <= '0;
              st       <= S_PRE;
            end
          end
        end

        S_PRE: begin
          mem_dq_oe <= 1'b0;
          if (cnt == pre_last) begin
            cnt <= '0;
            if (op == OP_DUM && dum < DCW'(N_DUMMY)) begin
              mem_ce_n <= 1'b0;
              dum      <= dum + 1'b1;
              st       <= S_LOW;
            end else begin
              st <= S_IDLE;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end

        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module psram_seq_props #(
  parameter int AW         = 19,
  parameter int DW         = 8,
  parameter int T_CE       = 7,
  parameter int T_WP       = 3,
  parameter int T_PRE      = 4,
  parameter int T_CYC      = 12,
  parameter int T_RMW      = 16,
  parameter int MAX_CE_LOW = 1000,
  parameter int N_DUMMY    = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ready,
  input logic          rd_valid,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ce_n,
  input logic          mem_oe_n,
  input logic          mem_we_n,
  input logic [DW-1:0] mem_dq_out,
  input logic          mem_dq_oe
);
  logic [15:0] lo_run, hi_run, per_run, nfall;
  logic        ce_q, seen_fall, oe_lo, rmw_win;
  logic        fall;

  assign fall = ce_q && !mem_ce_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_run    <= '0;
      hi_run    <= '0;
      per_run   <= '0;
      nfall     <= '0;
      ce_q      <= 1'b1;
      seen_fall <= 1'b0;
      oe_lo     <= 1'b0;
      rmw_win   <= 1'b0;
    end else begin
      ce_q      <= mem_ce_n;
      lo_run    <= mem_ce_n ? 16'd0 : lo_run + 16'd1;
      hi_run    <= !mem_ce_n ? 16'd0 : (&hi_run ? hi_run : hi_run + 16'd1);
      per_run   <= fall ? 16'd1 : (&per_run ? per_run : per_run + 16'd1);
      nfall     <= (fall && !(&nfall)) ? nfall + 16'd1 : nfall;
      seen_fall <= seen_fall | fall;
      oe_lo     <= fall ? !mem_oe_n : (oe_lo | (!mem_ce_n && !mem_oe_n));
      rmw_win   <= fall ? 1'b0 : (rmw_win | (!mem_we_n && oe_lo));
    end
  end

  p_addr_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n |=> $stable(mem_addr));
  p_ce_min_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_ce_n) |-> lo_run >= 16'(T_CE));
  p_ce_max_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lo_run <= 16'(MAX_CE_LOW));
  p_precharge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_ce_n) |-> hi_run >= 16'(T_PRE));
  p_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && seen_fall) |-> per_run >= (rmw_win ? 16'(T_RMW) : 16'(T_CYC)));
  p_we_in_ce_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce_n && mem_dq_oe));
  p_wdata_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |=> ($stable(mem_dq_out) && mem_dq_oe));
  p_rdvalid_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
  p_read_strobes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_ce_n && mem_we_n));
  p_dummies_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> nfall >= 16'(N_DUMMY));
  p_ready_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (mem_ce_n && !mem_dq_oe));
  p_no_clash_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);
  p_drive_after_oe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> $past(mem_oe_n));
endmodule

bind psram_seq psram_seq_props #(
  .AW(AW), .DW(DW), .T_CE(T_CE), .T_WP(T_WP), .T_PRE(T_PRE), .T_CYC(T_CYC),
  .T_RMW(T_RMW), .MAX_CE_LOW(MAX_CE_LOW), .N_DUMMY(N_DUMMY)
) i_props (
  .clk(clk), .rst_n(rst_n), .ready(ready), .rd_valid(rd_valid),
  .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
  .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe)
);

// File: tb/test_psram_seq.sv
module test_psram_seq;
  localparam int T_CE = 7, T_WP = 3, T_PRE = 4, T_CYC = 12, T_RMW = 16;
  localparam int PWRUP = 50, NDUM = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_op = 2'b00;
  logic [18:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic ready, rd_valid, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [7:0] rd_data, mem_dq_out, mem_dq_in;
  logic [18:0] mem_addr;

  always #5 clk = ~clk;

  psram_seq #(.PWRUP_CYC(PWRUP)) i_psram_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in));

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] ram [0:1023];
  logic [7:0] expm [0:1023];

  function automatic logic [9:0] idx(input logic [18:0] a);
    return {a[18:16], a[6:0]};
  endfunction

  function automatic logic [18:0] addr_of(input int k);
    logic [5:0] kk = 6'(k);
    return {kk[5:3], 9'(k * 37), kk[2:0], 4'(k)};
  endfunction

  assign mem_dq_in = (!mem_ce_n && !mem_oe_n && mem_we_n) ? ram[idx(mem_addr)] : 8'h00;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // pin-level monitor and memory model, sampled on the falling edge
  logic [1:0] cur_op = 2'd3, prev_op = 2'd3;
  bit user_mode = 0, seen_fall = 0, pend = 0, dummy_bad = 0;
  int lo_len = 0, hi_len = 0, per_len = 0, falls = 0, cyc = 0, first_fall = -1;
  logic ce_prev = 1'b1;
  logic [18:0] pa;
  logic [7:0] pd;

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      per_len++;
      if (ce_prev && !mem_ce_n) begin
        if (first_fall < 0) first_fall = cyc;
        if (!user_mode) falls++;
        if (user_mode && seen_fall) begin
          chk(hi_len >= T_PRE, "R3 precharge", hi_len, T_PRE);
          chk(per_len >= ((prev_op == 2'd2) ? T_RMW : T_CYC), "R3 cycle time",
              per_len, (prev_op == 2'd2) ? T_RMW : T_CYC);
        end
        seen_fall = 1;
        prev_op = cur_op;
        per_len = 0;
      end
      if (!ce_prev && mem_ce_n && user_mode)
        chk(lo_len == ((cur_op == 2'd2) ? T_CE + 1 + T_WP : T_CE), "R2 select width",
            lo_len, (cur_op == 2'd2) ? T_CE + 1 + T_WP : T_CE);
      if (!mem_ce_n && !user_mode && (!mem_oe_n || !mem_we_n)) dummy_bad = 1;
      lo_len = mem_ce_n ? 0 : lo_len + 1;
      hi_len = mem_ce_n ? hi_len + 1 : 0;
      if (mem_dq_oe && !mem_ce_n && !mem_oe_n && mem_we_n)
        chk(0, "R9 bus clash", 1, 0);
      if (!mem_ce_n && !mem_we_n) begin
        pend = 1; pa = mem_addr; pd = mem_dq_out;
      end else if (pend) begin
        chk(mem_dq_oe == 1'b1, "R4 data hold", mem_dq_oe, 1);
        ram[idx(pa)] = pd;
        pend = 0;
      end
      ce_prev = mem_ce_n;
    end
  end

  task automatic access(input logic [1:0] op, input logic [18:0] a,
                        input logic [7:0] d, output logic [7:0] r);
    int lat;
    r = '0;
    while (!ready) @(negedge clk);
    cur_op = (op == 2'b11) ? 2'b00 : op;
    req_valid = 1; req_op = op; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    chk(!ready, "R8 busy after accept", ready, 0);
    if (op != 2'b01) begin
      lat = 0;
      while (!rd_valid) begin @(negedge clk); lat++; end
      chk(lat == T_CE, "R5 read latency", lat, T_CE);
      r = rd_data;
      @(negedge clk);
      chk(!rd_valid, "R5 single-cycle valid", rd_valid, 0);
    end
    while (!ready) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    for (int i = 0; i < 1024; i++) begin
      ram[i] = 8'(i * 7 + 3);
      expm[i] = ram[i];
    end
    repeat (4) @(negedge clk);
    // R7 reset state
    chk(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe, "R7 reset strobes",
        {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b1110);
    chk(!ready && !rd_valid, "R7 reset ready", ready, 0);
    rst_n = 1;
    // R8: request held during power-up must be ignored
    req_valid = 1; req_op = 2'b01; req_addr = addr_of(5); req_wdata = 8'hA5;
    repeat (30) @(negedge clk);
    req_valid = 0;
    while (!ready) @(negedge clk);
    chk(first_fall >= PWRUP, "R7 settle delay", first_fall, PWRUP);
    chk(falls == NDUM, "R7 dummy count", falls, NDUM);
    chk(!dummy_bad, "R7 dummy strobes", dummy_bad, 0);
    user_mode = 1;
    access(2'b00, addr_of(5), 8'h00, r);
    chk(r == expm[idx(addr_of(5))], "R8 ignored request", r, expm[idx(addr_of(5))]);

    for (int k = 0; k < 64; k++) begin
      access(2'b01, addr_of(k), 8'(k * 29 + 7), r);
      expm[idx(addr_of(k))] = 8'(k * 29 + 7);
      chk(ram[idx(addr_of(k))] == expm[idx(addr_of(k))], "R4 write",
          ram[idx(addr_of(k))], expm[idx(addr_of(k))]);
    end
    for (int k = 0; k < 64; k++) begin
      access((k % 2 == 0) ? 2'b00 : 2'b11, addr_of(k), 8'h00, r);
      chk(r == expm[idx(addr_of(k))], "R5 read", r, expm[idx(addr_of(k))]);
      chk(mem_addr == addr_of(k), "R1 address", int'(mem_addr), int'(addr_of(k)));
    end
    for (int k = 0; k < 64; k++) begin
      access(2'b10, addr_of(k), 8'(~(k * 13)), r);
      chk(r == expm[idx(addr_of(k))], "R6 old data", r, expm[idx(addr_of(k))]);
      expm[idx(addr_of(k))] = 8'(~(k * 13));
      chk(ram[idx(addr_of(k))] == expm[idx(addr_of(k))], "R6 new data",
          ram[idx(addr_of(k))], expm[idx(addr_of(k))]);
    end
    for (int k = 0; k < 16; k++) begin
      access(2'(k % 3), addr_of(63 - k), 8'(k + 200), r);
      if (k % 3 != 1)
        chk(r == expm[idx(addr_of(63 - k))], "R6 mixed read", r, expm[idx(addr_of(63 - k))]);
      if (k % 3 != 0) expm[idx(addr_of(63 - k))] = 8'(k + 200);
      chk(ram[idx(addr_of(63 - k))] == expm[idx(addr_of(63 - k))], "R4 mixed contents",
          ram[idx(addr_of(63 - k))], expm[idx(addr_of(63 - k))]);
    end
    repeat (5) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule